// File: doc/BRIEF.md
# Bitwise Logic and Shift Unit

A purely combinational datapath slice for a 64-bit load/store processor. It carries out six bitwise logic operations, a flag-only test, four shift and rotate forms, and five sign or zero extensions. Every operation runs on either the full 64-bit operand or a 32-bit operand held in the low half. The caller gives an opcode, the operand size, two operands and a flag-set request. The unit returns a 64-bit result, a result write enable, the four condition flags and one flag write enable.

The shift count is taken from the low bits of the second operand. In 32-bit mode the upper half of every result is cleared. Bit 31 is then the sign bit for arithmetic shifts and for the negative flag. Decode, the register file, immediate expansion and the adder are outside this unit.

Top module: `bls_unit`

## Requirements
- R1: Opcodes 0 to 5 give a&b, a|b, a^b, a&~b, a|~b and a^~b on the selected width.
- R2: Opcode 4 with a zero first operand returns the bitwise inverse of the second operand.
- R3: Opcode 0 with set_flags high raises flag_we. flag_n is the result's sign bit (bit 63 when wide is 1, bit 31 when wide is 0). flag_z is high when the selected width of the result is zero. flag_c and flag_v are 0.
- R4: Opcode 6 (test) produces flags exactly as in R3, raises flag_we and holds res_we low, whatever set_flags is.
- R5: For any opcode other than 0 and 6, set_flags has no effect and flag_we is 0.
- R6: Opcode 7 shifts left and opcode 8 shifts right logically. Vacated positions fill with 0 and bits shifted past the edge are lost.
- R7: Opcode 9 shifts right arithmetically and copies the sign bit (63, or 31 in 32-bit mode) into every vacated position.
- R8: Opcode 10 rotates right. In 32-bit mode bits leaving bit 0 re-enter at bit 31, and bits 32 to 63 of the operand play no part.
- R9: The shift count is b[5:0] when wide is 1 and b[4:0] when wide is 0; higher bits of b are ignored.
- R10: Opcodes 11, 12 and 13 sign-extend from bit 7, 15 and 31 of a. Opcodes 14 and 15 zero-extend bits 7:0 and 15:0 of a.
- R11: When wide is 0, result bits 63 to 32 are 0 for every opcode.
- R12: res_we is 1 for every opcode except 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 4 | Operation code (see requirements) |
| wide | input | 1 | 1 = 64-bit operands, 0 = 32-bit operands |
| a | input | 64 | First operand / value to shift or extend |
| b | input | 64 | Second operand / shift count |
| set_flags | input | 1 | Request flag update on the AND operation |
| result | output | 64 | Operation result |
| res_we | output | 1 | Result is to be written back |
| flag_we | output | 1 | Flags are to be written |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The in-line checks assume each opcode is one of the sixteen defined codes, and that all inputs are stable when they are evaluated. The unit has no state, so no other input history is assumed. The stimulus draws opcodes from the full 4-bit space, which holds only legal codes. Operands and counts are drawn at random, so the bits above the count field and the unused upper operand half in 32-bit mode carry junk. Inputs change once per cycle, away from the sampling point. Directed vectors add the count edges: zero, the width minus one, and a count that wraps back to zero. They also add negative values for the sign-fill and sign-extension cases.

// File: rtl/bls_pkg.sv
package bls_pkg;
   typedef enum logic [3:0] {
      OP_AND  = 4'd0,
      OP_ORR  = 4'd1,
      OP_EOR  = 4'd2,
      OP_BIC  = 4'd3,
      OP_ORN  = 4'd4,
      OP_EON  = 4'd5,
      OP_TST  = 4'd6,
      OP_LSL  = 4'd7,
      OP_LSR  = 4'd8,
      OP_ASR  = 4'd9,
      OP_ROR  = 4'd10,
      OP_SXTB = 4'd11,
      OP_SXTH = 4'd12,
      OP_SXTW = 4'd13,
      OP_UXTB = 4'd14,
      OP_UXTH = 4'd15
   } bls_op_e;

   typedef enum logic [1:0] {
      CLS_LOGIC = 2'd0,
      CLS_SHIFT = 2'd1,
      CLS_EXT   = 2'd2
   } bls_cls_e;

   function automatic bls_cls_e op_class(input bls_op_e op);
      case (op)
         OP_LSL, OP_LSR, OP_ASR, OP_ROR:             op_class = CLS_SHIFT;
         OP_SXTB, OP_SXTH, OP_SXTW, OP_UXTB, OP_UXTH: op_class = CLS_EXT;
         default:                                    op_class = CLS_LOGIC;
      endcase
   endfunction
endpackage

// File: rtl/bls_logic.sv
module bls_logic
   import bls_pkg::*;
#(
   parameter int W = 64
) (
   input  bls_op_e        op,
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   output logic [W-1:0]   y
);
   always_comb begin
      case (op)
         OP_AND, OP_TST: y = a & b;
         OP_ORR:         y = a | b;
         OP_EOR:         y = a ^ b;
         OP_BIC:         y = a & ~b;
         OP_ORN:         y = a | ~b;
         OP_EON:         y = a ^ ~b;
         default:        y = '0;
      endcase
   end

   // a cleared-by-mask result never shares a set bit with the mask
   always_comb begin
      if (op == OP_BIC)
         assert_bic_disjoint_R1: assert ((y & b) == '0)
            else $error("bit clear left a masked bit set");
   end
endmodule

// File: rtl/bls_shift.sv
module bls_shift
   import bls_pkg::*;
#(
   parameter int W  = 64,
   localparam int CW = $clog2(W),
   localparam int H  = W / 2
) (
   input  bls_op_e        op,
   input  logic           wide,
   input  logic [W-1:0]   a,
   input  logic [CW-1:0]  cnt_raw,
   output logic [W-1:0]   y
);
   logic [CW-1:0] cnt;
   logic [W-1:0]  src;
   logic [W-1:0]  src_dir;
   logic          go_left;
   logic          is_rot;
   logic          fill;
   logic [W-1:0]  stg [0:CW];
   logic [W-1:0]  fin;

   assign go_left = (op == OP_LSL);
   assign is_rot  = (op == OP_ROR);
   assign cnt     = wide ? cnt_raw : {1'b0, cnt_raw[CW-2:0]};

   // operand prepared so one right-moving network serves every form
   always_comb begin
      case (op)
         OP_ASR:  src = wide ? a : {{H{a[H-1]}}, a[H-1:0]};
         OP_ROR:  src = wide ? a : {a[H-1:0], a[H-1:0]};
         default: src = wide ? a : {{H{1'b0}}, a[H-1:0]};
      endcase
   end

   assign fill = (op == OP_ASR) ? src[W-1] : 1'b0;

   always_comb begin
      for (int i = 0; i < W; i++)
         src_dir[i] = go_left ? src[W-1-i] : src[i];
   end

   assign stg[0] = src_dir;

   generate
      for (genvar k = 0; k < CW; k++) begin : g_stage
         localparam int S = 1 << k;
         always_comb begin
            if (!cnt[k])
               stg[k+1] = stg[k];
            else if (is_rot)
               stg[k+1] = {stg[k][S-1:0], stg[k][W-1:S]};
            else
               stg[k+1] = {{S{fill}}, stg[k][W-1:S]};
         end
      end
   endgenerate

   always_comb begin
      for (int i = 0; i < W; i++)
         fin[i] = go_left ? stg[CW][W-1-i] : stg[CW][i];
   end

   assign y = fin;

   // a zero effective count must pass the prepared operand unchanged
   always_comb begin
      if (cnt == '0)
         assert_zero_count_R9: assert (fin == src)
            else $error("zero count altered the operand");
   end
endmodule

// File: rtl/bls_extend.sv
module bls_extend
   import bls_pkg::*;
#(
   parameter int W = 64,
   localparam int H = W / 2
) (
   input  bls_op_e        op,
   input  logic [W-1:0]   a,
   output logic [W-1:0]   y
);
   always_comb begin
      case (op)
         OP_SXTB: y = {{(W-8){a[7]}}, a[7:0]};
         OP_SXTH: y = {{(W-16){a[15]}}, a[15:0]};
         OP_SXTW: y = {{(W-H){a[H-1]}}, a[H-1:0]};
         OP_UXTB: y = {{(W-8){1'b0}}, a[7:0]};
         OP_UXTH: y = {{(W-16){1'b0}}, a[15:0]};
         default: y = '0;
      endcase
   end

   always_comb begin
      if (op == OP_UXTB || op == OP_UXTH)
         assert_zext_bound_R10: assert (y <= W'(16'hFFFF))
            else $error("zero extension set a high bit");
   end
endmodule

// File: rtl/bls_unit.sv
module bls_unit
   import bls_pkg::*;
#(
   parameter int W = 64,
   localparam int CW = $clog2(W),
   localparam int H  = W / 2
) (
   input  logic [3:0]    op,
   input  logic          wide,
   input  logic [W-1:0]  a,
   input  logic [W-1:0]  b,
   input  logic          set_flags,
   output logic [W-1:0]  result,
   output logic          res_we,
   output logic          flag_we,
   output logic          flag_n,
   output logic          flag_z,
   output logic          flag_c,
   output logic          flag_v
);
   generate
      if (W < 32 || (1 << CW) != W) begin : g_bad_width
         $error("bls_unit: W must be a power of two of at least 32");
      end
   endgenerate

   bls_op_e      opc;
   logic [W-1:0] y_log, y_sh, y_ext, y_sel;

   assign opc = bls_op_e'(op);

   bls_logic #(.W(W)) u_logic (.op(opc), .a(a), .b(b), .y(y_log));

   bls_shift #(.W(W)) u_shift (
      .op(opc), .wide(wide), .a(a), .cnt_raw(b[CW-1:0]), .y(y_sh)
   );

   bls_extend #(.W(W)) u_ext (.op(opc), .a(a), .y(y_ext));

   always_comb begin
      case (op_class(opc))
         CLS_SHIFT: y_sel = y_sh;
         CLS_EXT:   y_sel = y_ext;
         default:   y_sel = y_log;
      endcase
   end

   assign result  = wide ? y_sel : {{H{1'b0}}, y_sel[H-1:0]};
   assign res_we  = (opc != OP_TST);
   assign flag_we = (opc == OP_TST) || (opc == OP_AND && set_flags);
   assign flag_n  = wide ? y_sel[W-1] : y_sel[H-1];
   assign flag_z  = wide ? (y_sel == '0) : (y_sel[H-1:0] == '0);
   assign flag_c  = 1'b0;
   assign flag_v  = 1'b0;

   always_comb begin
      if (!wide)
         assert_upper_clear_R11: assert (result[W-1:H] == '0)
            else $error("32-bit result leaked into upper half");
      if (flag_we)
         assert_cv_zero_R3: assert (!flag_c && !flag_v)
            else $error("carry or overflow set on logic flags");
      if (opc == OP_TST)
         assert_test_no_write_R4: assert (!res_we && flag_we)
            else $error("test wrote a result or skipped the flags");
      if (flag_we && flag_n)
         assert_neg_nonzero_R3: assert (!flag_z)
            else $error("negative and zero both set");
   end
endmodule

// File: tb/sim_bls_unit.sv
module sim_bls_unit;
   logic        clk = 1'b0;
   logic [3:0]  op;
   logic        wide;
   logic [63:0] a, b;
   logic        set_flags;
   logic [63:0] result;
   logic        res_we, flag_we, flag_n, flag_z, flag_c, flag_v;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   bls_unit u0 (
      .op(op), .wide(wide), .a(a), .b(b), .set_flags(set_flags),
      .result(result), .res_we(res_we), .flag_we(flag_we),
      .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
   );

   function automatic logic [63:0] model(input logic [3:0] o, input logic w,
                                         input logic [63:0] x, input logic [63:0] y);
      logic [63:0] r;
      logic [31:0] x32;
      int n;
      x32 = x[31:0];
      n = w ? int'(y[5:0]) : int'(y[4:0]);
      case (o)
         4'd0, 4'd6: r = x & y;
         4'd1:  r = x | y;
         4'd2:  r = x ^ y;
         4'd3:  r = x & ~y;
         4'd4:  r = x | ~y;
         4'd5:  r = ~(x ^ y);
         4'd7:  r = w ? (x << n) : {32'd0, x32 << n};
         4'd8:  r = w ? (x >> n) : {32'd0, x32 >> n};
         4'd9:  r = w ? 64'($signed(x) >>> n) : {32'd0, 32'($signed(x32) >>> n)};
         4'd10: begin
            if (w) r = (n == 0) ? x : ((x >> n) | (x << (64 - n)));
            else   r = {32'd0, (n == 0) ? x32 : ((x32 >> n) | (x32 << (32 - n)))};
         end
         4'd11: r = 64'(signed'(x[7:0]));
         4'd12: r = 64'(signed'(x[15:0]));
         4'd13: r = 64'(signed'(x[31:0]));
         4'd14: r = {56'd0, x[7:0]};
         default: r = {48'd0, x[15:0]};
      endcase
      if (!w) r[63:32] = 32'd0;
      return r;
   endfunction

   function automatic string tag(input logic [3:0] o, input logic w);
      if (!w) return "R11";
      case (o)
         4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5: return "R1";
         4'd6: return "R4";
         4'd7, 4'd8: return "R6";
         4'd9: return "R7";
         4'd10: return "R8";
         default: return "R10";
      endcase
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic apply(input logic [3:0] o, input logic w, input logic [63:0] x,
                        input logic [63:0] y, input logic sf, input string req);
      logic [63:0] e;
      logic        fwe;
      @(negedge clk);
      op = o; wide = w; a = x; b = y; set_flags = sf;
      #2;
      e   = model(o, w, x, y);
      fwe = (o == 4'd6) || (o == 4'd0 && sf);
      chk(req, result, e);
      chk((o == 4'd6) ? "R4" : "R12", 64'(res_we), 64'(o != 4'd6));
      chk((o == 4'd0 || o == 4'd6) ? "R3" : "R5", 64'(flag_we), 64'(fwe));
      if (fwe) begin
         chk("R3", {60'd0, flag_n, flag_z, flag_c, flag_v},
             {60'd0, w ? e[63] : e[31], w ? (e == 0) : (e[31:0] == 0), 1'b0, 1'b0});
      end
   endtask

   initial begin
      #1_900_000;
      errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd355));
      op = '0; wide = 1'b1; a = '0; b = '0; set_flags = 1'b0;
      // idle state: all-zero inputs
      apply(4'd0, 1'b1, 64'd0, 64'd0, 1'b0, "R1");
      apply(4'd0, 1'b1, 64'hAA, 64'hF0, 1'b0, "R1");
      apply(4'd3, 1'b1, 64'hFF, 64'h3C, 1'b0, "R1");
      apply(4'd4, 1'b1, 64'd0, 64'h0123_4567_89AB_CDEF, 1'b0, "R2");
      apply(4'd4, 1'b0, 64'd0, 64'h0000_0000_0000_00FF, 1'b0, "R2");
      apply(4'd0, 1'b1, 64'h8000_0000_0000_0001, 64'hFFFF_0000_0000_0001, 1'b1, "R3");
      apply(4'd0, 1'b0, 64'hFFFF_FFFF_8000_0000, 64'h0000_0000_8000_0000, 1'b1, "R3");
      apply(4'd6, 1'b1, 64'h10, 64'h8, 1'b0, "R4");
      apply(4'd6, 1'b1, 64'h18, 64'h8, 1'b1, "R4");
      apply(4'd1, 1'b1, 64'h5, 64'h30, 1'b1, "R5");
      apply(4'd7, 1'b1, 64'h5, 64'd3, 1'b1, "R5");
      apply(4'd7, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd63, 1'b0, "R6");
      apply(4'd8, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd31, 1'b0, "R6");
      apply(4'd9, 1'b1, 64'hFFFF_FFFF_FFFF_FFF8, 64'd1, 1'b0, "R7");
      apply(4'd9, 1'b0, 64'h0000_0000_8000_0000, 64'd4, 1'b0, "R7");
      apply(4'd10, 1'b0, 64'hDEAD_BEEF_0000_0001, 64'd1, 1'b0, "R8");
      apply(4'd10, 1'b1, 64'h0000_0000_0000_0001, 64'd1, 1'b0, "R8");
      apply(4'd7, 1'b1, 64'h3, 64'hFFFF_FFFF_FFFF_FF40, 1'b0, "R9");
      apply(4'd8, 1'b0, 64'hF0, 64'h20, 1'b0, "R9");
      apply(4'd10, 1'b0, 64'h1234_5678, 64'h3F, 1'b0, "R9");
      apply(4'd11, 1'b1, 64'hFF, 64'd0, 1'b0, "R10");
      apply(4'd11, 1'b1, 64'h7F, 64'd0, 1'b0, "R10");
      apply(4'd13, 1'b1, 64'h0000_0000_8000_0000, 64'd0, 1'b0, "R10");
      apply(4'd15, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1'b0, "R10");
      apply(4'd12, 1'b0, 64'h8000, 64'd0, 1'b0, "R11");
      apply(4'd13, 1'b0, 64'h0000_0000_8000_0000, 64'd0, 1'b0, "R11");
      for (int i = 0; i < 3000; i++) begin
         logic [3:0] o;
         logic       w;
         o = 4'($urandom_range(0, 15));
         w = 1'($urandom);
         apply(o, w, {$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), tag(o, w));
      end
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule